// File: doc/BRIEF.md
# Joint Page-Pair Translation Buffer

This block is a fully associative address translation buffer. A single table of entries serves both the instruction-fetch lookup port and the data-access lookup port. Each entry covers two neighbouring virtual pages, an even one and an odd one, and maps them to two separate physical frames. Each entry carries its own page-size code, from 4 KB up to 16 MB in steps of four. A lookup returns the following fields for the page it selects: whether an entry matched, the physical address, the page's valid and dirty bits, its 3-bit cache attribute, and a flag that is set when that attribute means write-back caching.

Software loads entries through an indexed write port. Software can also probe the table with a virtual page-pair number to find which index holds the mapping. Each lookup port is a valid/ready stream with a single register stage:
- A request is taken in a cycle where both `lk_valid` and `lk_ready` are high.
- The result appears on the `rs_*` outputs in the next cycle.
- While `rs_valid` is high and `rs_ready` is low, the result holds and the port refuses new requests.

The probe and the write port are plain strobes with no back-pressure. The current address-space ID (`cur_asid`) is one shared input used by both lookup ports and by the probe.

Top module: `jtlb`

## Requirements
- R1: After reset, no entry is live. Every lookup returns `rs_hit`=0 with all page fields and `rs_pa` at zero, every probe reports `probe_fail`=1, and `rs_valid` is 0 on both ports.
- R2: `wr_en` writes the entry at `wr_idx` and marks it live. An index of 48 or more is ignored. Each page word is laid out as PFN in bits [28:5], cache attribute in [4:2], dirty in [1] and valid in [0]. A write is seen by lookups and probes accepted in the following cycle, but not in the same cycle.
- R3: With size code s (page size 4 KB·4^s), an entry matches when VA[31:13+2s] equals the stored page-pair number with its low 2s bits ignored. Size codes above 6 act as 6. All entries are searched, at any index.
- R4: A non-global entry matches only when its stored ASID equals `cur_asid`. A global entry ignores the ASID.
- R5: VA bit 12+2s selects the page within the pair: 0 gives the even page and 1 gives the odd page.
- R6: `rs_pa` is {PFN, VA[11:0]}, with the low 2s bits of the PFN replaced by VA[11+2s:12].
- R7: On a hit, `rs_pgvalid`, `rs_dirty` and `rs_cattr` come from the selected page, and `rs_wb` is 1 exactly when `rs_cattr` is 3. A hit on a page whose valid bit is 0 reports `rs_hit`=1 with `rs_pgvalid`=0. On a miss, all of these fields are 0.
- R8: When two or more entries match, `rs_multi` is 1 and the lowest-index match supplies the result.
- R9: `lk_ready` = !`rs_valid` || `rs_ready`. An accepted request gives `rs_valid`=1 in the next cycle. A held result stays unchanged while `rs_ready` is low.
- R10: Both lookup ports search the same table independently, in the same cycle.
- R11: A `probe_en` cycle sets `probe_done` in the next cycle. The result is either the lowest matching index in `probe_idx` with `probe_fail`=0, or `probe_fail`=1 with `probe_idx`=0. A probe match uses the tag and ASID rules only. Page validity and even/odd selection play no part in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | 8 | Current address-space ID |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn2 | input | 19 | Virtual page-pair number (VA[31:13]) |
| wr_size | input | 3 | Page-size code s |
| wr_asid | input | 8 | Entry ASID |
| wr_global | input | 1 | Entry ignores the ASID |
| wr_even | input | 29 | Even page word |
| wr_odd | input | 29 | Odd page word |
| lk_valid | input | 2 | Request valid (port 0 fetch, port 1 data) |
| lk_ready | output | 2 | Request ready |
| lk_va | input | 2x32 | Virtual address per port |
| rs_valid | output | 2 | Result valid |
| rs_ready | input | 2 | Result taken |
| rs_hit | output | 2 | An entry matched |
| rs_pgvalid | output | 2 | Selected page valid bit |
| rs_dirty | output | 2 | Selected page dirty bit |
| rs_wb | output | 2 | Attribute means write-back |
| rs_multi | output | 2 | More than one entry matched |
| rs_cattr | output | 2x3 | Cache attribute |
| rs_pa | output | 2x36 | Physical address |
| probe_en | input | 1 | Probe strobe |
| probe_vpn2 | input | 19 | Page-pair number to probe |
| probe_done | output | 1 | Probe result valid |
| probe_fail | output | 1 | No entry matched |
| probe_idx | output | 6 | Lowest matching index |

## Verification
A corrupted tag, size code or live bit shows up at the ports on the next result after a lookup in the affected region. It appears as a spurious hit or miss, a wrong `rs_multi`, or a shifted boundary between the even and odd pages. A corrupted page word shows up one cycle after acceptance, as a wrong `rs_pa`, attribute or flag. The reference model predicts every output field on every clock, so a divergence is caught in the first cycle it is visible. That cycle is the cycle after the lookup or probe that touches the faulty entry.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;
  parameter int VA_W   = 32;
  parameter int PA_W   = 36;
  parameter int ASID_W = 8;
  parameter int OFF_W  = 12;
  parameter int SZ_W   = 3;
  parameter int CA_W   = 3;
  parameter int MAX_SZ = 6;
  localparam int VPN2_W = VA_W - OFF_W - 1;
  localparam int PFN_W  = PA_W - OFF_W;
  localparam int PTE_W  = PFN_W + CA_W + 2;
  localparam logic [CA_W-1:0] CA_WRITEBACK = 3'd3;

  typedef struct packed {
    logic              live;
    logic [VPN2_W-1:0] vpn2;
    logic [SZ_W-1:0]   sz;
    logic [ASID_W-1:0] asid;
    logic              g;
  } tag_t;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [CA_W-1:0]  ca;
    logic             d;
    logic             v;
  } pte_t;

  function automatic logic [SZ_W-1:0] clamp_sz(input logic [SZ_W-1:0] s);
    return (s > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : s;
  endfunction

  function automatic logic [VPN2_W-1:0] cmp_mask(input logic [SZ_W-1:0] s);
    logic [VPN2_W-1:0] one;
    one = VPN2_W'(1);
    return ~((one << {s, 1'b0}) - one);
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store import jtlb_pkg::*; #(
  parameter int N     = 48,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  pte_t              wr_even,
  input  pte_t              wr_odd,
  output tag_t [N-1:0]      tags,
  output pte_t [N-1:0]      evens,
  output pte_t [N-1:0]      odds
);
  logic idx_ok;
  assign idx_ok = ({1'b0, wr_idx} < (IDX_W+1)'(N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tags  <= '0;
      evens <= '0;
      odds  <= '0;
    end else if (wr_en && idx_ok) begin
      tags[wr_idx]  <= '{live: 1'b1, vpn2: wr_vpn2, sz: clamp_sz(wr_size),
                         asid: wr_asid, g: wr_global};
      evens[wr_idx] <= wr_even;
      odds[wr_idx]  <= wr_odd;
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match import jtlb_pkg::*; #(
  parameter int N     = 48,
  parameter int IDX_W = 6
) (
  input  tag_t [N-1:0]      tags,
  input  logic [VPN2_W-1:0] vpn2,
  input  logic [ASID_W-1:0] asid,
  output logic              found,
  output logic              multi,
  output logic [IDX_W-1:0]  idx
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = tags[i].live
                 && (((tags[i].vpn2 ^ vpn2) & cmp_mask(tags[i].sz)) == '0)
                 && (tags[i].g || (tags[i].asid == asid));
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    found = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        if (found) multi = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import jtlb_pkg::*; #(
  parameter int N     = 48,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tag_t [N-1:0]      tags,
  input  pte_t [N-1:0]      evens,
  input  pte_t [N-1:0]      odds,
  input  logic [ASID_W-1:0] asid,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   va,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic              rs_pgvalid,
  output logic              rs_dirty,
  output logic              rs_wb,
  output logic              rs_multi,
  output logic [CA_W-1:0]   rs_cattr,
  output logic [PA_W-1:0]   rs_pa
);
  logic             found, multi;
  logic [IDX_W-1:0] idx;
  logic [SZ_W-1:0]  sz;
  logic [3:0]       shift;
  logic             odd_sel;
  pte_t             pte;
  logic [PFN_W-1:0] pmask;
  logic [PA_W-1:0]  pa_n;

  tlb_match #(.N(N), .IDX_W(IDX_W)) u_match (
    .tags (tags),
    .vpn2 (va[VA_W-1:OFF_W+1]),
    .asid (asid),
    .found(found),
    .multi(multi),
    .idx  (idx)
  );

  always_comb begin
    sz      = tags[idx].sz;
    shift   = {sz, 1'b0};
    odd_sel = va[OFF_W + int'(shift)];
    pte     = odd_sel ? odds[idx] : evens[idx];
    pmask   = (PFN_W'(1) << shift) - PFN_W'(1);
    pa_n    = {(pte.pfn & ~pmask) | (PFN_W'(va[VA_W-1:OFF_W]) & pmask),
               va[OFF_W-1:0]};
  end

  assign lk_ready = !rs_valid || rs_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid   <= 1'b0;
      rs_hit     <= 1'b0;
      rs_pgvalid <= 1'b0;
      rs_dirty   <= 1'b0;
      rs_wb      <= 1'b0;
      rs_multi   <= 1'b0;
      rs_cattr   <= '0;
      rs_pa      <= '0;
    end else if (lk_valid && lk_ready) begin
      rs_valid   <= 1'b1;
      rs_hit     <= found;
      rs_multi   <= multi;
      rs_pgvalid <= found && pte.v;
      rs_dirty   <= found && pte.d;
      rs_cattr   <= found ? pte.ca : '0;
      rs_wb      <= found && (pte.ca == CA_WRITEBACK);
      rs_pa      <= found ? pa_n : '0;
    end else if (rs_ready) begin
      rs_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/jtlb.sv
module jtlb import jtlb_pkg::*; #(
  parameter int NUM_ENTRIES = 48,
  parameter int NPORT       = 2,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ASID_W-1:0]           cur_asid,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [VPN2_W-1:0]           wr_vpn2,
  input  logic [SZ_W-1:0]             wr_size,
  input  logic [ASID_W-1:0]           wr_asid,
  input  logic                        wr_global,
  input  logic [PTE_W-1:0]            wr_even,
  input  logic [PTE_W-1:0]            wr_odd,
  input  logic [NPORT-1:0]            lk_valid,
  output logic [NPORT-1:0]            lk_ready,
  input  logic [NPORT-1:0][VA_W-1:0]  lk_va,
  output logic [NPORT-1:0]            rs_valid,
  input  logic [NPORT-1:0]            rs_ready,
  output logic [NPORT-1:0]            rs_hit,
  output logic [NPORT-1:0]            rs_pgvalid,
  output logic [NPORT-1:0]            rs_dirty,
  output logic [NPORT-1:0]            rs_wb,
  output logic [NPORT-1:0]            rs_multi,
  output logic [NPORT-1:0][CA_W-1:0]  rs_cattr,
  output logic [NPORT-1:0][PA_W-1:0]  rs_pa,
  input  logic                        probe_en,
  input  logic [VPN2_W-1:0]           probe_vpn2,
  output logic                        probe_done,
  output logic                        probe_fail,
  output logic [IDX_W-1:0]            probe_idx
);
  tag_t [NUM_ENTRIES-1:0] tags;
  pte_t [NUM_ENTRIES-1:0] evens;
  pte_t [NUM_ENTRIES-1:0] odds;

  tlb_store #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_size(wr_size),
    .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_even(wr_even), .wr_odd(wr_odd),
    .tags(tags), .evens(evens), .odds(odds)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    tlb_xlate #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_xlate (
      .clk(clk), .rst_n(rst_n),
      .tags(tags), .evens(evens), .odds(odds), .asid(cur_asid),
      .lk_valid(lk_valid[p]), .lk_ready(lk_ready[p]), .va(lk_va[p]),
      .rs_valid(rs_valid[p]), .rs_ready(rs_ready[p]),
      .rs_hit(rs_hit[p]), .rs_pgvalid(rs_pgvalid[p]), .rs_dirty(rs_dirty[p]),
      .rs_wb(rs_wb[p]), .rs_multi(rs_multi[p]),
      .rs_cattr(rs_cattr[p]), .rs_pa(rs_pa[p])
    );
  end

  logic             pr_found, pr_multi;
  logic [IDX_W-1:0] pr_idx;

  tlb_match #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_probe (
    .tags(tags), .vpn2(probe_vpn2), .asid(cur_asid),
    .found(pr_found), .multi(pr_multi), .idx(pr_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      probe_done <= 1'b0;
      probe_fail <= 1'b0;
      probe_idx  <= '0;
    end else begin
      probe_done <= probe_en;
      if (probe_en) begin
        probe_fail <= !pr_found;
        probe_idx  <= (pr_found || pr_multi) ? pr_idx : '0;
      end
    end
  end
endmodule

// File: rtl/jtlb_chk.sv
module jtlb_chk import jtlb_pkg::*; #(
  parameter int NPORT = 2,
  parameter int IDX_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NPORT-1:0]           lk_valid,
  input logic [NPORT-1:0]           lk_ready,
  input logic [NPORT-1:0]           rs_valid,
  input logic [NPORT-1:0]           rs_ready,
  input logic [NPORT-1:0]           rs_hit,
  input logic [NPORT-1:0]           rs_pgvalid,
  input logic [NPORT-1:0]           rs_dirty,
  input logic [NPORT-1:0]           rs_wb,
  input logic [NPORT-1:0]           rs_multi,
  input logic [NPORT-1:0][CA_W-1:0] rs_cattr,
  input logic [NPORT-1:0][PA_W-1:0] rs_pa,
  input logic                       probe_en,
  input logic                       probe_done,
  input logic                       probe_fail,
  input logic [IDX_W-1:0]           probe_idx
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid[p] && !rs_ready[p] |=> rs_valid[p] && $stable(rs_pa[p])
        && $stable(rs_hit[p]) && $stable(rs_cattr[p]));
    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid[p] && lk_ready[p] |=> rs_valid[p]);
    // R7
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid[p] && !rs_hit[p] |-> !rs_pgvalid[p] && !rs_dirty[p]
        && !rs_wb[p] && (rs_pa[p] == '0));
    // R8
    multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_multi[p] |-> rs_hit[p]);
    // R7
    wb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid[p] && rs_wb[p] |-> rs_cattr[p] == 3'd3);
  end

  // R11
  probe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_en |=> probe_done);
  // R11
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_en |=> !probe_done);
  // R11
  probe_fail_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_done && probe_fail |-> probe_idx == '0);
endmodule

bind jtlb jtlb_chk #(.NPORT(NPORT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
  .rs_pgvalid(rs_pgvalid), .rs_dirty(rs_dirty), .rs_wb(rs_wb),
  .rs_multi(rs_multi), .rs_cattr(rs_cattr), .rs_pa(rs_pa),
  .probe_en(probe_en), .probe_done(probe_done), .probe_fail(probe_fail),
  .probe_idx(probe_idx)
);

// File: tb/sim_jtlb.sv
module sim_jtlb;
  localparam int N = 48;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]        cur_asid = '0;
  logic              wr_en = 1'b0;
  logic [5:0]        wr_idx = '0;
  logic [18:0]       wr_vpn2 = '0;
  logic [2:0]        wr_size = '0;
  logic [7:0]        wr_asid = '0;
  logic              wr_global = 1'b0;
  logic [28:0]       wr_even = '0, wr_odd = '0;
  logic [1:0]        lk_valid = '0, rs_ready = '0;
  logic [1:0][31:0]  lk_va = '0;
  logic              probe_en = 1'b0;
  logic [18:0]       probe_vpn2 = '0;
  logic [1:0]        lk_ready, rs_valid, rs_hit, rs_pgvalid, rs_dirty, rs_wb, rs_multi;
  logic [1:0][2:0]   rs_cattr;
  logic [1:0][35:0]  rs_pa;
  logic              probe_done, probe_fail;
  logic [5:0]        probe_idx;

  jtlb u0 (.*);

  // reference state
  logic        m_live [N];
  logic [18:0] m_vpn2 [N];
  int          m_sz   [N];
  logic [7:0]  m_asid [N];
  logic        m_g    [N];
  logic [28:0] m_ev   [N];
  logic [28:0] m_od   [N];
  logic        e_valid [2], e_hit [2], e_pv [2], e_d [2], e_wb [2], e_multi [2];
  logic [2:0]  e_ca [2];
  logic [35:0] e_pa [2];
  logic        e_pdone = 0, e_pfail = 0;
  logic [5:0]  e_pidx = '0;

  int    nchk = 0, nfail = 0;
  bit    finished = 0;
  string phase = "R1 reset";

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", req, phase, act, exp, $time);
    end
  endtask

  function automatic bit tag_eq(input int i, input logic [18:0] v2);
    return m_live[i] && (m_g[i] || m_asid[i] == cur_asid)
        && ((v2 >> (2 * m_sz[i])) == (m_vpn2[i] >> (2 * m_sz[i])));
  endfunction

  task automatic mx(input int p);
    logic [31:0] va;
    int sel, cnt, ob;
    logic [28:0] w;
    longint unsigned base;
    va = lk_va[p]; sel = -1; cnt = 0;
    for (int i = 0; i < N; i++)
      if (tag_eq(i, va[31:13])) begin cnt++; if (sel < 0) sel = i; end
    e_hit[p] = 0; e_pv[p] = 0; e_d[p] = 0; e_wb[p] = 0; e_ca[p] = 0; e_pa[p] = 0;
    e_multi[p] = (cnt > 1);
    if (sel >= 0) begin
      ob = 12 + 2 * m_sz[sel];
      w = va[ob] ? m_od[sel] : m_ev[sel];
      base = longint'(w[28:5]) << 12;
      e_hit[p] = 1; e_pv[p] = w[0]; e_d[p] = w[1]; e_ca[p] = w[4:2];
      e_wb[p] = (w[4:2] == 3);
      e_pa[p] = 36'(((base >> ob) << ob) | (longint'(va) & ((64'd1 << ob) - 1)));
    end
  endtask

  task automatic model_next();
    for (int p = 0; p < 2; p++) begin
      if (lk_valid[p] && (!e_valid[p] || rs_ready[p])) begin
        mx(p); e_valid[p] = 1;
      end else if (rs_ready[p]) e_valid[p] = 0;
    end
    e_pdone = probe_en;
    if (probe_en) begin
      e_pfail = 1; e_pidx = 0;
      for (int i = N - 1; i >= 0; i--)
        if (tag_eq(i, probe_vpn2)) begin e_pfail = 0; e_pidx = 6'(i); end
    end
    if (wr_en && wr_idx < N) begin
      m_live[wr_idx] = 1; m_vpn2[wr_idx] = wr_vpn2;
      m_sz[wr_idx] = (wr_size > 6) ? 6 : int'(wr_size);
      m_asid[wr_idx] = wr_asid; m_g[wr_idx] = wr_global;
      m_ev[wr_idx] = wr_even; m_od[wr_idx] = wr_odd;
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      chk("R9 rs_valid", rs_valid[p], e_valid[p]);
      chk("R9 lk_ready", lk_ready[p], !e_valid[p] || rs_ready[p]);
      if (e_valid[p]) begin
        chk("R3 hit", rs_hit[p], e_hit[p]);
        chk("R7 pgvalid", rs_pgvalid[p], e_pv[p]);
        chk("R7 dirty", rs_dirty[p], e_d[p]);
        chk("R7 cattr", rs_cattr[p], e_ca[p]);
        chk("R7 wb", rs_wb[p], e_wb[p]);
        chk("R8 multi", rs_multi[p], e_multi[p]);
        chk("R6 pa", rs_pa[p], e_pa[p]);
      end
    end
    chk("R11 done", probe_done, e_pdone);
    if (e_pdone) begin
      chk("R11 fail", probe_fail, e_pfail);
      chk("R11 idx", probe_idx, e_pidx);
    end
  endtask

  task automatic tick();
    model_next();
    @(negedge clk);
    compare();
    wr_en = 0; probe_en = 0;
  endtask

  task automatic wr(input int idx, input logic [18:0] v2, input int sz,
                    input logic [7:0] a, input bit g, input logic [28:0] ev, od);
    wr_en = 1; wr_idx = 6'(idx); wr_vpn2 = v2; wr_size = 3'(sz);
    wr_asid = a; wr_global = g; wr_even = ev; wr_odd = od;
  endtask

  function automatic logic [31:0] va_of(input logic [18:0] v2, input int sz,
                                        input bit odd, input logic [31:0] off);
    return {v2, 13'b0} | (32'(odd) << (12 + 2 * sz)) | off;
  endfunction

  function automatic logic [28:0] pw(input logic [23:0] pfn, input logic [2:0] ca,
                                     input bit d, input bit v);
    return {pfn, ca, d, v};
  endfunction

  task automatic look(input logic [31:0] a0, input logic [31:0] a1);
    lk_valid = 2'b11; rs_ready = 2'b11; lk_va[0] = a0; lk_va[1] = a1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_live[i] = 0; m_vpn2[i] = 0; m_sz[i] = 0; m_asid[i] = 0; m_g[i] = 0;
      m_ev[i] = 0; m_od[i] = 0;
    end
    for (int p = 0; p < 2; p++) begin
      e_valid[p] = 0; e_hit[p] = 0; e_pv[p] = 0; e_d[p] = 0; e_wb[p] = 0;
      e_multi[p] = 0; e_ca[p] = 0; e_pa[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare();
    // R1: empty table misses and fails
    look(32'h0, 32'h1234_5000); probe_en = 1; probe_vpn2 = '0; tick();
    lk_valid = 0; tick();
    // R2: write and lookup in the same cycle, then the next
    phase = "R2 write";
    wr(5, 19'h00123, 0, 8'd1, 0, pw(24'hABCDE, 3, 1, 1), pw(24'h11111, 2, 0, 1));
    cur_asid = 8'd1;
    look(va_of(19'h00123, 0, 0, 32'h345), va_of(19'h00123, 0, 1, 32'hFFF)); tick();
    look(va_of(19'h00123, 0, 0, 32'h345), va_of(19'h00123, 0, 1, 32'hFFF)); tick();
    wr(50, 19'h00777, 0, 8'd1, 1, pw(24'h1, 3, 0, 1), pw(24'h2, 3, 0, 1)); tick();
    look(va_of(19'h00777, 0, 0, 0), va_of(19'h00777, 0, 1, 0)); tick();
    // R3 R5 R6: every page size, edges of both halves and beyond
    phase = "R3 R5 R6 sizes";
    for (int s = 0; s < 8; s++) begin
      wr(10 + s, 19'((s + 1) << 14), s, 8'd9, 1,
         pw(24'hF0F0F0 + 24'(s), 3'(s), s[0], 1), pw(24'h0F0F0F - 24'(s), 3'(s + 1), !s[0], s != 2));
      tick();
    end
    for (int s = 0; s < 8; s++) begin
      int se;
      logic [31:0] lim;
      se = (s > 6) ? 6 : s;
      lim = (32'd1 << (12 + 2 * se)) - 1;
      look(va_of(19'((s + 1) << 14), se, 0, 0), va_of(19'((s + 1) << 14), se, 0, lim)); tick();
      look(va_of(19'((s + 1) << 14), se, 1, 0), va_of(19'((s + 1) << 14), se, 1, lim)); tick();
      look(va_of(19'((s + 1) << 14), se, 1, lim) + 1, {19'((s + 1) << 14), 13'b0} - 1); tick();
    end
    // R4: ASID filtering
    phase = "R4 asid";
    wr(30, 19'h04444, 1, 8'd3, 0, pw(24'h333, 0, 0, 1), pw(24'h444, 3, 1, 1)); tick();
    cur_asid = 8'd3; look(va_of(19'h04444, 1, 0, 5), va_of(19'h04444, 1, 1, 7)); tick();
    cur_asid = 8'd4; look(va_of(19'h04444, 1, 0, 5), va_of(19'h04444, 1, 1, 7)); tick();
    probe_en = 1; probe_vpn2 = 19'h04444; tick();
    cur_asid = 8'd3; probe_en = 1; probe_vpn2 = 19'h04444; tick();
    // R8: two overlapping entries, lowest index wins
    phase = "R8 multi";
    wr(40, 19'h05500, 2, 8'd0, 1, pw(24'hAAAA, 3, 1, 1), pw(24'hBBBB, 0, 0, 0)); tick();
    wr(20, 19'h05500, 0, 8'd0, 1, pw(24'hCCCC, 2, 0, 1), pw(24'hDDDD, 1, 1, 0)); tick();
    look(va_of(19'h05500, 0, 0, 9), va_of(19'h05500, 0, 1, 9)); probe_en = 1;
    probe_vpn2 = 19'h05500; tick();
    look(va_of(19'h05502, 2, 0, 9), va_of(19'h05500, 2, 1, 9)); tick();
    // R9: back-pressure
    phase = "R9 backpressure";
    look(va_of(19'h00123, 0, 0, 1), va_of(19'h05500, 0, 0, 2)); rs_ready = 2'b00; tick();
    for (int k = 0; k < 4; k++) begin
      lk_va[0] = lk_va[0] + 32'h1000; lk_va[1] = lk_va[1] ^ 32'h2000;
      rs_ready = (k == 2) ? 2'b01 : 2'b00; tick();
    end
    rs_ready = 2'b11; lk_valid = 2'b00; tick(); tick();
    // R10 R2 R11: random traffic on both ports with writes and probes
    phase = "R10 random";
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < 2; p++) begin
        int e;
        e = $urandom_range(N - 1);
        lk_valid[p] = ($urandom_range(3) != 0);
        rs_ready[p] = ($urandom_range(3) != 0);
        if (m_live[e] && $urandom_range(3) != 0)
          lk_va[p] = {m_vpn2[e], 13'b0} ^ ($urandom() & ((32'd1 << (13 + 2 * m_sz[e])) - 1));
        else lk_va[p] = $urandom();
      end
      if ($urandom_range(7) == 0) cur_asid = 8'($urandom_range(3));
      if ($urandom_range(3) == 0)
        wr($urandom_range(55), 19'({$urandom_range(7), 12'h0}) | 19'($urandom_range(3)),
           $urandom_range(7), 8'($urandom_range(3)), $urandom_range(1),
           29'($urandom()), 29'($urandom()));
      if ($urandom_range(2) == 0) begin
        probe_en = 1;
        probe_vpn2 = 19'({$urandom_range(7), 12'h0}) | 19'($urandom_range(3));
      end
      tick();
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired [%s]", phase);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule